// File: doc/BRIEF.md
# Posted Register Write Synchronizer

This block sits between a fast bus clock and a slow timer clock. It owns the crossing for ten timer registers that live on the slow side. Each of them has its own write-pending flag. A bus write to one of these registers is captured in a per-register holding register. It is then sent across with a toggle handshake, and it lands on the slow side as a single-cycle update strobe with the held value. The pending flag drops once the acknowledge toggle has come back through a two-flop synchronizer.

Two policies are offered, chosen by a mode bit. In posted mode the bus gets its response one cycle after acceptance, and the crossing finishes in the background. A second write to a register that is still in flight is dropped, and this is flagged. A read of such a register answers with an error. In non-posted mode a slow-register access holds the bus until the crossing has finished. Reads of slow registers are served from bus-side shadow copies. These copies are reloaded by the write acknowledge and by a background snapshot loop that runs continuously.

Top module: `posted_write_sync`

## Requirements
- R1: After reset, req_ready is 1, the pending status reads 0, and the mode register reads 0x4, so posted mode is the default.
- R2: A read at offset 0x34 returns the pending flags one cycle after acceptance, with no error. The bit map is: 0 = 0x24, 1 = 0x28, 2 = 0x2C, 3 = 0x30, 4 = 0x38, 5 = 0x48, 6 = 0x4C, 7 = 0x50, 8 = 0x54, 9 = 0x58.
- R3: In posted mode a write to a slow register responds one cycle after acceptance. Its flag is set from the next cycle on. Its value later arrives at upd_data with exactly one upd_stb pulse, and then the flag clears.
- R4: In posted mode a write to a register whose flag is set is discarded. drop_err is high for one cycle, together with the response, and the slow side keeps the earlier value.
- R5: In posted mode a read of a register whose flag is set responds with rsp_err = 1 and data 0.
- R6: In non-posted mode a slow-register write responds only after its value has landed on the slow side. If the flag was already set, the write waits for it to clear and is then sent. req_ready stays low during the stall.
- R7: In non-posted mode a read of a register whose flag is set waits until the flag clears. It then returns the written value with no error.
- R8: A read of a slow register whose flag is clear returns the last value that landed for it.
- R9: Offset 0x40 holds only the mode bit at position 2 (1 = posted). All other bits read as 0, and writes to it take effect at once.
- R10: Any other offset responds one cycle after acceptance, with data 0 and no error, in either mode.
- R11: While a register's flag is set, its upd_data slice does not change. Each upd_stb bit is high for no more than one slow cycle in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DW | Read data (0 for writes) |
| rsp_err | output | 1 | Read refused, write still pending |
| drop_err | output | 1 | Posted write discarded |
| fclk | input | 1 | Slow timer clock |
| frst_n | input | 1 | Slow-domain reset, active low |
| upd_stb | output | 10 | Per-register update strobe, slow domain |
| upd_data | output | 10*DW | Held values, register i at slice i |
| slow_val | input | 10*DW | Current slow-side register values for the shadow |

## Verification
Posted, local and unmapped accesses are due at the first negative edge after the accepting edge. The bench therefore samples the response there and requires a latency of exactly one cycle. The pending flag can be seen from the next access onward. It clears only after two to three slow cycles plus two bus cycles, so the bench runs back-to-back checks well inside that window and otherwise polls the status register up to a bound. For non-posted accesses the bench measures how long the response takes, and at the response cycle it checks that the value has landed on the slow side and that the status reads zero.

// File: rtl/posted_write_sync.sv
module posted_write_sync #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [7:0] STAT_OFF = 8'h34,
  parameter logic [7:0] MODE_OFF = 8'h40,
  parameter int MODE_BIT = 2,
  localparam int NREG = 10,
  localparam int IW = $clog2(NREG)
) (
  input  logic                 bclk,
  input  logic                 brst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_err,
  output logic                 drop_err,
  input  logic                 fclk,
  input  logic                 frst_n,
  output logic [NREG-1:0]      upd_stb,
  output logic [NREG*DW-1:0]   upd_data,
  input  logic [NREG*DW-1:0]   slow_val
);
  localparam logic [NREG-1:0][7:0] SLOW_OFF =
    {8'h58, 8'h54, 8'h50, 8'h4c, 8'h48, 8'h38, 8'h30, 8'h2c, 8'h28, 8'h24};

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_DRAIN} st_t;

  st_t st;
  logic posted, wr_op;
  logic sreq, sa_s1, sa_s2, sr_s1, sr_s2, sr_s3;
  logic [IW-1:0] cidx, widx;
  logic [DW-1:0] wdat, ldat;
  logic [NREG-1:0] hit, launch, req_tgl, ack_s1, ack_s2, pend, done, clean;
  logic [NREG-1:0] rq_s1, rq_s2, rq_s3;
  logic [NREG-1:0][DW-1:0] hold, shadow, snap;

  wire acc         = req_valid && req_ready;
  wire is_stat     = req_addr == AW'(STAT_OFF);
  wire is_mode     = req_addr == AW'(MODE_OFF);
  wire apply       = sa_s1 ^ sa_s2;
  wire outstanding = sreq ^ sa_s2;

  assign req_ready = st == ST_IDLE;
  assign pend      = req_tgl ^ ack_s2;
  assign done      = ack_s1 ^ ack_s2;
  assign ldat      = (st == ST_HOLD) ? wdat : req_wdata;
  assign upd_stb   = rq_s2 ^ rq_s3;
  assign upd_data  = hold;

  always_comb begin
    hit  = '0;
    cidx = '0;
    for (int i = 0; i < NREG; i++)
      if (req_addr == AW'(SLOW_OFF[i])) begin
        hit[i] = 1'b1;
        cidx   = IW'(i);
      end
  end

  always_comb begin
    launch = '0;
    if (acc && |hit && req_write && !pend[cidx]) launch[cidx] = 1'b1;
    if (st == ST_HOLD && wr_op && !pend[widx]) launch[widx] = 1'b1;
  end

  // launch side: toggle out, acknowledge back
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_tgl <= '0;
      hold    <= '0;
      ack_s1  <= '0;
      ack_s2  <= '0;
    end else begin
      ack_s1 <= rq_s3;
      ack_s2 <= ack_s1;
      for (int i = 0; i < NREG; i++)
        if (launch[i]) begin
          req_tgl[i] <= ~req_tgl[i];
          hold[i]    <= ldat;
        end
    end
  end

  // shadow copies: reload on acknowledge, refresh from snapshot when clean
  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      shadow <= '0;
      clean  <= '0;
      sreq   <= 1'b0;
      sa_s1  <= 1'b0;
      sa_s2  <= 1'b0;
    end else begin
      sa_s1 <= sr_s3;
      sa_s2 <= sa_s1;
      if (!outstanding) begin
        sreq  <= ~sreq;
        clean <= ~pend & ~launch;
      end else begin
        clean <= clean & ~launch;
      end
      for (int i = 0; i < NREG; i++)
        if (done[i]) shadow[i] <= hold[i];
        else if (apply && clean[i] && !pend[i] && !launch[i]) shadow[i] <= snap[i];
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      st        <= ST_IDLE;
      posted    <= 1'b1;
      wr_op     <= 1'b0;
      widx      <= '0;
      wdat      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      drop_err  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      drop_err  <= 1'b0;
      case (st)
        ST_IDLE: if (acc) begin
          if (|hit) begin
            if (posted) begin
              rsp_valid <= 1'b1;
              if (req_write)          drop_err  <= pend[cidx];
              else if (pend[cidx])    rsp_err   <= 1'b1;
              else                    rsp_rdata <= shadow[cidx];
            end else begin
              widx  <= cidx;
              wdat  <= req_wdata;
              wr_op <= req_write;
              if (req_write)          st <= pend[cidx] ? ST_HOLD : ST_DRAIN;
              else if (pend[cidx])    st <= ST_HOLD;
              else begin
                rsp_valid <= 1'b1;
                rsp_rdata <= shadow[cidx];
              end
            end
          end else begin
            rsp_valid <= 1'b1;
            if (is_stat && !req_write) rsp_rdata <= DW'(pend);
            if (is_mode) begin
              if (req_write) posted <= req_wdata[MODE_BIT];
              else           rsp_rdata[MODE_BIT] <= posted;
            end
          end
        end
        ST_HOLD: if (!pend[widx]) begin
          if (wr_op) st <= ST_DRAIN;
          else begin
            st        <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= shadow[widx];
          end
        end
        ST_DRAIN: if (!pend[widx]) begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // slow side
  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      rq_s1 <= '0;
      rq_s2 <= '0;
      rq_s3 <= '0;
      sr_s1 <= 1'b0;
      sr_s2 <= 1'b0;
      sr_s3 <= 1'b0;
      snap  <= '0;
    end else begin
      rq_s1 <= req_tgl;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
      sr_s1 <= sreq;
      sr_s2 <= sr_s1;
      sr_s3 <= sr_s2;
      if (sr_s2 ^ sr_s3) snap <= slow_val;
    end
  end
endmodule

// File: rtl/posted_write_sync_chk.sv
module posted_write_sync_chk #(
  parameter int DW = 32,
  parameter int NREG = 10
) (
  input logic                bclk,
  input logic                brst_n,
  input logic                fclk,
  input logic                frst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic                drop_err,
  input logic                posted,
  input logic [NREG-1:0]     pend,
  input logic [NREG-1:0]     upd_stb,
  input logic [NREG*DW-1:0]  upd_data
);
  assert_drop_with_rsp_R4: assert property (@(posedge bclk) disable iff (!brst_n)
    drop_err |-> (rsp_valid && !rsp_err));

  assert_rd_err_only_posted_R5: assert property (@(posedge bclk) disable iff (!brst_n)
    (rsp_valid && rsp_err) |-> $past(posted));

  assert_pend_set_by_write_R3: assert property (@(posedge bclk) disable iff (!brst_n)
    ((pend & ~$past(pend)) != '0) |-> ($past(req_valid && req_ready && req_write) || $past(!req_ready)));

  assert_stall_only_nonposted_R6: assert property (@(posedge bclk) disable iff (!brst_n)
    !req_ready |-> !posted);

  assert_single_strobe_R11: assert property (@(posedge fclk) disable iff (!frst_n)
    (upd_stb & $past(upd_stb)) == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_hold
    assert_hold_stable_R11: assert property (@(posedge bclk) disable iff (!brst_n)
      (pend[i] && $past(pend[i])) |-> $stable(upd_data[i*DW +: DW]));
  end
endmodule

bind posted_write_sync posted_write_sync_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .bclk(bclk), .brst_n(brst_n), .fclk(fclk), .frst_n(frst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .drop_err(drop_err),
  .posted(posted), .pend(pend), .upd_stb(upd_stb), .upd_data(upd_data)
);

// File: tb/posted_write_sync_tb.sv
module posted_write_sync_tb;
  localparam int DW = 32;
  localparam int N  = 10;
  localparam logic [7:0] OFF [N] = '{8'h24, 8'h28, 8'h2c, 8'h30, 8'h38,
                                     8'h48, 8'h4c, 8'h50, 8'h54, 8'h58};

  logic bclk = 0, fclk = 0, brst_n = 0, frst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, drop_err;
  logic [DW-1:0] rsp_rdata;
  logic [N-1:0] upd_stb;
  logic [N*DW-1:0] upd_data, slow_val;
  logic [DW-1:0] slow_reg [N];
  int stb_cnt [N];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 bclk = ~bclk;
  always #30.5 fclk = ~fclk;

  posted_write_sync u_dut (
    .bclk(bclk), .brst_n(brst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .drop_err(drop_err),
    .fclk(fclk), .frst_n(frst_n), .upd_stb(upd_stb), .upd_data(upd_data), .slow_val(slow_val)
  );

  initial for (int i = 0; i < N; i++) begin slow_reg[i] = '0; stb_cnt[i] = 0; end

  always @(posedge fclk)
    for (int i = 0; i < N; i++)
      if (upd_stb[i]) begin
        slow_reg[i] <= upd_data[i*DW +: DW];
        stb_cnt[i]  <= stb_cnt[i] + 1;
      end

  always_comb for (int i = 0; i < N; i++) slow_val[i*DW +: DW] = slow_reg[i];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output bit err, output bit drp, output int lat);
    @(negedge bclk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge bclk);
    @(negedge bclk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 5000) begin @(negedge bclk); lat++; end
    rd = rsp_rdata; err = rsp_err; drp = drop_err;
  endtask

  task automatic wait_idle();
    logic [31:0] rd; bit e, d; int l;
    for (int k = 0; k < 300; k++) begin
      xfer(0, 8'h34, 0, rd, e, d, l);
      if (rd == 0) break;
    end
  endtask

  logic [31:0] exp_v [N];

  initial begin
    logic [31:0] rd; bit e, d; int l; int s0;
    for (int i = 0; i < N; i++) exp_v[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge bclk);
    brst_n = 1; frst_n = 1;
    @(negedge bclk);

    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    xfer(0, 8'h34, 0, rd, e, d, l);
    chk(rd == 0 && !e, "R1 status after reset", rd, 0);
    xfer(0, 8'h40, 0, rd, e, d, l);
    chk(rd == 32'h4, "R1 posted default", rd, 32'h4);

    xfer(1, 8'h40, 32'h0, rd, e, d, l);
    xfer(0, 8'h40, 0, rd, e, d, l);
    chk(rd == 0, "R9 mode cleared", rd, 0);
    xfer(1, 8'h40, 32'hffff_ffff, rd, e, d, l);
    xfer(0, 8'h40, 0, rd, e, d, l);
    chk(rd == 32'h4, "R9 only mode bit stored", rd, 32'h4);

    xfer(0, 8'h00, 0, rd, e, d, l);
    chk(rd == 0 && !e && l == 1, "R10 unmapped read", {rd[15:0], 16'(l)}, 1);
    xfer(1, 8'h10, 32'h55, rd, e, d, l);
    chk(l == 1 && !e && !d, "R10 unmapped write", l, 1);

    // posted write, drop, error read
    s0 = stb_cnt[1];
    xfer(1, OFF[1], 32'hA5A5_0001, rd, e, d, l);
    chk(l == 1 && !d, "R3 posted write latency", l, 1);
    xfer(0, 8'h34, 0, rd, e, d, l);
    chk(rd == 32'h2, "R2 counter flag at bit 1", rd, 32'h2);
    xfer(1, OFF[1], 32'hDEAD_BEEF, rd, e, d, l);
    chk(d == 1 && l == 1, "R4 drop flagged", d, 1);
    xfer(0, OFF[1], 0, rd, e, d, l);
    chk(e == 1 && rd == 0, "R5 read of pending errors", {31'(rd), e}, 1);
    wait_idle();
    chk(slow_reg[1] == 32'hA5A5_0001, "R4 slow keeps first value", slow_reg[1], 32'hA5A5_0001);
    chk(stb_cnt[1] - s0 == 1, "R3 single strobe", stb_cnt[1] - s0, 1);
    xfer(0, OFF[1], 0, rd, e, d, l);
    chk(rd == 32'hA5A5_0001 && !e, "R8 read landed value", rd, 32'hA5A5_0001);
    exp_v[1] = 32'hA5A5_0001;

    // multiple flags
    xfer(1, OFF[0], 32'h11, rd, e, d, l);
    xfer(1, OFF[4], 32'h44, rd, e, d, l);
    xfer(1, OFF[9], 32'h99, rd, e, d, l);
    xfer(0, 8'h34, 0, rd, e, d, l);
    chk(rd == 32'h211, "R2 bits 0,4,9", rd, 32'h211);
    wait_idle();
    chk(slow_reg[0] == 32'h11 && slow_reg[4] == 32'h44 && slow_reg[9] == 32'h99,
        "R3 three values landed", slow_reg[9], 32'h99);
    exp_v[0] = 32'h11; exp_v[4] = 32'h44; exp_v[9] = 32'h99;

    // non-posted write
    xfer(1, 8'h40, 32'h0, rd, e, d, l);
    xfer(1, OFF[2], 32'hC0C0_C0C0, rd, e, d, l);
    chk(l > 3 && slow_reg[2] == 32'hC0C0_C0C0, "R6 stall until landed", slow_reg[2], 32'hC0C0_C0C0);
    xfer(0, 8'h34, 0, rd, e, d, l);
    chk(rd == 0, "R6 nothing pending after stall", rd, 0);
    exp_v[2] = 32'hC0C0_C0C0;

    // non-posted read of pending register
    xfer(1, 8'h40, 32'h4, rd, e, d, l);
    xfer(1, OFF[7], 32'h7777_0007, rd, e, d, l);
    xfer(1, 8'h40, 32'h0, rd, e, d, l);
    xfer(0, OFF[7], 0, rd, e, d, l);
    chk(!e && rd == 32'h7777_0007 && l > 1, "R7 waited read", rd, 32'h7777_0007);
    exp_v[7] = 32'h7777_0007;

    // non-posted write to pending register
    s0 = stb_cnt[8];
    xfer(1, 8'h40, 32'h4, rd, e, d, l);
    xfer(1, OFF[8], 32'hE, rd, e, d, l);
    xfer(1, 8'h40, 32'h0, rd, e, d, l);
    xfer(1, OFF[8], 32'hF, rd, e, d, l);
    chk(!d && slow_reg[8] == 32'hF, "R6 queued behind pending", slow_reg[8], 32'hF);
    chk(stb_cnt[8] - s0 == 2, "R6 two strobes", stb_cnt[8] - s0, 2);
    exp_v[8] = 32'hF;

    // random mix
    for (int it = 0; it < 60; it++) begin
      int idx; logic [31:0] v; bit pm;
      idx = $urandom_range(N - 1);
      v   = $urandom;
      pm  = $urandom_range(1);
      xfer(1, 8'h40, pm ? 32'h4 : 32'h0, rd, e, d, l);
      xfer(1, OFF[idx], v, rd, e, d, l);
      if (pm) begin
        chk(l == 1 && !d, "R3 random posted write", l, 1);
        if ($urandom_range(1)) begin
          xfer(1, OFF[idx], ~v, rd, e, d, l);
          chk(d == 1, "R4 random drop", d, 1);
        end
        wait_idle();
      end else begin
        chk(slow_reg[idx] == v, "R6 random non-posted landed", slow_reg[idx], v);
      end
      exp_v[idx] = v;
      xfer(0, OFF[idx], 0, rd, e, d, l);
      chk(rd == exp_v[idx] && !e, "R8 random readback", rd, exp_v[idx]);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(64'd8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1..: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule